// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit keeps the two vector-length registers of a vector-capable core: the maximum vector length (called the limit here) and the current vector length. Each cycle it may receive one 48-bit instruction word with a valid strobe. The earlier decode stage also supplies the parts of that word the unit needs: a 12-bit length-type control field, an unsigned immediate, a destination register index and the value of a scalar source register. If the seven low bits of the word carry the vector-length prefix, the unit classifies the control field and updates its registers. It then sends the resulting current length back to the scalar register file.

The control field selects one of four behaviours. An all-zero field does nothing. With bit 11 set, the unit either loads both registers from the immediate (bit 0 clear) or loads only the limit and pulls the current length down to fit (bit 0 set). With bit 11 clear, the unit runs in loop mode. It takes a requested length from the immediate (bit 0 clear) or from the scalar operand (bit 0 set) and grants the smaller of that request and the present limit.

The writeback is a one-cycle valid pulse with no ready input. The register file must accept it in the cycle it appears, so the unit applies no back-pressure and accepts an instruction in every cycle. Register index 0 never receives a writeback.

Top module: `vlcfg_unit`

## Requirements
- R1: An instruction is acted on only when `insn_word[6:0]` equals 7'b0011111 (0x1F). A valid word with any other low field leaves both registers unchanged and raises no writeback.
- R2: A recognised instruction whose `vl_type` is all zero changes neither register and raises no writeback.
- R3: With `vl_type[11]`=1 and `vl_type[0]`=0, both `maxvl` and `vl` become `imm`+1.
- R4: With `vl_type[11]`=1 and `vl_type[0]`=1, `maxvl` becomes `imm`+1. `vl` keeps its value unless that value exceeds the new limit, in which case it becomes the new limit.
- R5: With `vl_type[11]`=0, `vl_type[0]`=0 and `vl_type` non-zero, `vl` becomes the smaller of `imm`+1 and the current `maxvl`, and `maxvl` is unchanged.
- R6: With `vl_type[11]`=0 and `vl_type[0]`=1, `vl` becomes the smaller of the full-width `rs_val` and the current `maxvl`, and `maxvl` is unchanged. A request of 0 grants 0.
- R7: Every state-changing instruction raises `wb_valid` for exactly one cycle, at the clock edge after the strobe. It carries `wb_idx` = `rd_idx` and `wb_data` = the new `vl`, zero-extended. When `rd_idx` is 0, the state still changes but `wb_valid` stays low.
- R8: After reset, `maxvl` = 1, `vl` = 1 and `wb_valid` = 0.
- R9: `vl` never exceeds `maxvl`.
- R10: With `insn_valid` low, nothing changes, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction strobe for this cycle |
| insn_word | input | WORD_W | Instruction word; bits 6:0 hold the prefix |
| vl_type | input | 12 | Length-type control field |
| imm | input | IMM_W | Unsigned length immediate (length minus one) |
| rd_idx | input | IDX_W | Scalar destination register index |
| rs_val | input | XLEN | Scalar source operand for loop register form |
| maxvl | output | IMM_W+1 | Current limit register |
| vl | output | IMM_W+1 | Current vector length register |
| wb_valid | output | 1 | One-cycle scalar writeback request |
| wb_idx | output | IDX_W | Writeback destination index |
| wb_data | output | XLEN | Writeback value (new vl, zero-extended) |

## Verification
The bench builds the unit with IMM_W = 4, so the length registers are 5 bits wide and the largest immediate (15) yields the full-scale length 16. That reaches the top of the register range in a handful of vectors. XLEN stays at 32, so a scalar request with a bit set far above the length width exercises the full-width comparison in loop register mode. Narrow lengths also make it cheap to walk the limit down to 1 and to grant a length of 0.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  localparam logic [6:0] VL_PREFIX = 7'b0011111;

  typedef enum logic [2:0] {
    VM_NONE,
    VM_SET_BOTH,
    VM_SET_MAX,
    VM_LOOP_IMM,
    VM_LOOP_REG
  } vl_mode_e;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter int WORD_W = 48
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic [11:0]       vl_type,
  output vl_mode_e          mode,
  output logic              act
);
  logic hit;

  assign hit = (word[6:0] == VL_PREFIX);

  always_comb begin
    if (vl_type == 12'd0)      mode = VM_NONE;
    else if (vl_type[11])      mode = vl_type[0] ? VM_SET_MAX  : VM_SET_BOTH;
    else                       mode = vl_type[0] ? VM_LOOP_REG : VM_LOOP_IMM;
  end

  assign act = valid && hit && (mode != VM_NONE);
endmodule

// File: rtl/vlcfg_next.sv
module vlcfg_next
  import vlcfg_pkg::*;
#(
  parameter int IMM_W = 6,
  parameter int XLEN  = 32,
  localparam int VL_W = IMM_W + 1
) (
  input  vl_mode_e         mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [VL_W-1:0]  cur_max,
  input  logic [VL_W-1:0]  cur_vl,
  output logic [VL_W-1:0]  nxt_max,
  output logic [VL_W-1:0]  nxt_vl
);
  logic [VL_W-1:0] imm_len;
  logic [VL_W-1:0] imm_grant;
  logic [VL_W-1:0] reg_grant;
  logic [VL_W-1:0] clamp_vl;

  assign imm_len   = VL_W'(imm) + VL_W'(1);
  assign imm_grant = (imm_len > cur_max) ? cur_max : imm_len;
  assign clamp_vl  = (cur_vl > imm_len) ? imm_len : cur_vl;

  generate
    if (XLEN > VL_W) begin : g_wide
      assign reg_grant = (rs_val >= XLEN'(cur_max)) ? cur_max : rs_val[VL_W-1:0];
    end else begin : g_narrow
      logic [VL_W-1:0] rs_ext;
      assign rs_ext    = VL_W'(rs_val);
      assign reg_grant = (rs_ext >= cur_max) ? cur_max : rs_ext;
    end
  endgenerate

  always_comb begin
    nxt_max = cur_max;
    nxt_vl  = cur_vl;
    unique case (mode)
      VM_SET_BOTH: begin nxt_max = imm_len; nxt_vl = imm_len;  end
      VM_SET_MAX:  begin nxt_max = imm_len; nxt_vl = clamp_vl; end
      VM_LOOP_IMM: nxt_vl = imm_grant;
      VM_LOOP_REG: nxt_vl = reg_grant;
      default: ;
    endcase
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int WORD_W = 48,
  parameter int IMM_W  = 6,
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  localparam int VL_W  = IMM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [WORD_W-1:0] insn_word,
  input  logic [11:0]       vl_type,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [XLEN-1:0]   rs_val,
  output logic [VL_W-1:0]   maxvl,
  output logic [VL_W-1:0]   vl,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  vl_mode_e        mode;
  logic            act;
  logic [VL_W-1:0] nxt_max;
  logic [VL_W-1:0] nxt_vl;

  vlcfg_decode #(.WORD_W(WORD_W)) u_dec (
    .valid   (insn_valid),
    .word    (insn_word),
    .vl_type (vl_type),
    .mode    (mode),
    .act     (act)
  );

  vlcfg_next #(.IMM_W(IMM_W), .XLEN(XLEN)) u_nxt (
    .mode    (mode),
    .imm     (imm),
    .rs_val  (rs_val),
    .cur_max (maxvl),
    .cur_vl  (vl),
    .nxt_max (nxt_max),
    .nxt_vl  (nxt_vl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxvl    <= VL_W'(1);
      vl       <= VL_W'(1);
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= 1'b0;
      if (act) begin
        maxvl    <= nxt_max;
        vl       <= nxt_vl;
        wb_valid <= (rd_idx != '0);
        wb_idx   <= rd_idx;
        wb_data  <= XLEN'(nxt_vl);
      end
    end
  end
endmodule

module vlcfg_unit_chk #(
  parameter int WORD_W = 48,
  parameter int IMM_W  = 6,
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  localparam int VL_W  = IMM_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_valid,
  input logic [WORD_W-1:0] insn_word,
  input logic [11:0]       vl_type,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [VL_W-1:0]   maxvl,
  input logic [VL_W-1:0]   vl,
  input logic              wb_valid,
  input logic [IDX_W-1:0]  wb_idx,
  input logic [XLEN-1:0]   wb_data
);
  // R9
  vl_within_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vl <= maxvl);

  // R1
  foreign_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_word[6:0] != 7'b0011111) |=> ($stable(maxvl) && $stable(vl) && !wb_valid));

  // R1
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn_word == '0) |=> !wb_valid);

  // R2
  null_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && vl_type == 12'd0) |=> ($stable(maxvl) && $stable(vl) && !wb_valid));

  // R5
  loop_keeps_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !vl_type[11]) |=> $stable(maxvl));

  // R7
  wb_carries_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data == XLEN'(vl) && wb_idx != '0));

  // R7
  wb_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(insn_valid) && $past(rd_idx) == wb_idx));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> ($stable(maxvl) && $stable(vl) && !wb_valid));
endmodule

bind vlcfg_unit vlcfg_unit_chk #(
  .WORD_W(WORD_W), .IMM_W(IMM_W), .XLEN(XLEN), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_valid (insn_valid),
  .insn_word  (insn_word),
  .vl_type    (vl_type),
  .rd_idx     (rd_idx),
  .maxvl      (maxvl),
  .vl         (vl),
  .wb_valid   (wb_valid),
  .wb_idx     (wb_idx),
  .wb_data    (wb_data)
);

// File: tb/vlcfg_unit_bench.sv
module vlcfg_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 48;
  localparam int IMM_W  = 4;
  localparam int XLEN   = 32;
  localparam int IDX_W  = 5;
  localparam int VL_W   = IMM_W + 1;
  localparam int NVEC   = 14;

  // fields: opc(7) type(12) imm(4) rd(5) rs(32) exp_max(5) exp_vl(5) exp_wb(1)
  localparam logic [70:0] VECS [NVEC] = '{
    {7'h1F, 12'h800, 4'd7,  5'd3,  32'd0,          5'd8,  5'd8,  1'b1}, // R3
    {7'h1F, 12'h801, 4'd3,  5'd4,  32'd0,          5'd4,  5'd4,  1'b1}, // R4 clamp down
    {7'h1F, 12'h801, 4'd9,  5'd0,  32'd0,          5'd10, 5'd4,  1'b0}, // R4 keep, R7 rd zero
    {7'h1F, 12'h002, 4'd5,  5'd1,  32'd0,          5'd10, 5'd6,  1'b1}, // R5 under limit
    {7'h1F, 12'h002, 4'd15, 5'd2,  32'd0,          5'd10, 5'd10, 1'b1}, // R5 over limit
    {7'h1F, 12'h001, 4'd0,  5'd5,  32'd3,          5'd10, 5'd3,  1'b1}, // R6
    {7'h1F, 12'h001, 4'd0,  5'd6,  32'h0001_0002,  5'd10, 5'd10, 1'b1}, // R6 wide request
    {7'h1F, 12'h000, 4'd2,  5'd7,  32'd0,          5'd10, 5'd10, 1'b0}, // R2
    {7'h1E, 12'h800, 4'd1,  5'd7,  32'd0,          5'd10, 5'd10, 1'b0}, // R1
    {7'h5F, 12'h800, 4'd1,  5'd7,  32'd0,          5'd10, 5'd10, 1'b0}, // R1
    {7'h1F, 12'h800, 4'd15, 5'd31, 32'd0,          5'd16, 5'd16, 1'b1}, // R3 full scale
    {7'h1F, 12'h801, 4'd0,  5'd8,  32'd0,          5'd1,  5'd1,  1'b1}, // R4 limit one
    {7'h1F, 12'h001, 4'd0,  5'd9,  32'd0,          5'd1,  5'd0,  1'b1}, // R6 zero grant
    {7'h1F, 12'h800, 4'd0,  5'd0,  32'd0,          5'd1,  5'd1,  1'b0}  // R3, R7 rd zero
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              insn_valid = 1'b0;
  logic [WORD_W-1:0] insn_word = '0;
  logic [11:0]       vl_type = '0;
  logic [IMM_W-1:0]  imm = '0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [XLEN-1:0]   rs_val = '0;
  logic [VL_W-1:0]   maxvl;
  logic [VL_W-1:0]   vl;
  logic              wb_valid;
  logic [IDX_W-1:0]  wb_idx;
  logic [XLEN-1:0]   wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlcfg_unit #(.WORD_W(WORD_W), .IMM_W(IMM_W), .XLEN(XLEN), .IDX_W(IDX_W)) u_vlcfg_unit (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .vl_type(vl_type), .imm(imm), .rd_idx(rd_idx), .rs_val(rs_val),
    .maxvl(maxvl), .vl(vl), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] opc, input logic [11:0] t, input logic [IMM_W-1:0] im,
                       input logic [IDX_W-1:0] rd, input logic [XLEN-1:0] rs);
    insn_valid = 1'b1;
    insn_word  = {41'h0A5_5A5A_3C3C, opc};
    vl_type    = t;
    imm        = im;
    rd_idx     = rd;
    rs_val     = rs;
  endtask

  task automatic idle();
    insn_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 maxvl in reset", 64'(maxvl), 64'd1);
    chk("R8 vl in reset", 64'(vl), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 maxvl after reset", 64'(maxvl), 64'd1);
    chk("R8 vl after reset", 64'(vl), 64'd1);
    chk("R8 wb_valid after reset", 64'(wb_valid), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [70:0] v;
      v = VECS[i];
      drive(v[70:64], v[63:52], v[51:48], v[47:43], v[42:11]);
      @(negedge clk);
      idle();
      chk($sformatf("vector %0d maxvl", i), 64'(maxvl), 64'(v[10:6]));
      chk($sformatf("vector %0d vl", i), 64'(vl), 64'(v[5:1]));
      chk($sformatf("R7 vector %0d wb_valid", i), 64'(wb_valid), 64'(v[0]));
      if (v[0]) begin
        chk($sformatf("R7 vector %0d wb_idx", i), 64'(wb_idx), 64'(v[47:43]));
        chk($sformatf("R7 vector %0d wb_data", i), 64'(wb_data), 64'(v[5:1]));
      end
      @(negedge clk);
      chk($sformatf("R7 vector %0d pulse ends", i), 64'(wb_valid), 64'd0);
      chk($sformatf("R9 vector %0d vl within limit", i), 64'(vl <= maxvl), 64'd1);
    end

    // R10: matching word with strobe low has no effect
    drive(7'h1F, 12'h800, 4'd11, 5'd3, 32'd0);
    insn_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 maxvl held", 64'(maxvl), 64'd1);
    chk("R10 vl held", 64'(vl), 64'd1);
    chk("R10 no writeback", 64'(wb_valid), 64'd0);

    // back-to-back: set both to 12, then loop imm request 5 -> 5
    drive(7'h1F, 12'h800, 4'd11, 5'd10, 32'd0);
    @(negedge clk);
    chk("R3 back-to-back first maxvl", 64'(maxvl), 64'd12);
    chk("R7 back-to-back first data", 64'(wb_data), 64'd12);
    drive(7'h1F, 12'h7FE, 4'd4, 5'd11, 32'd0);
    @(negedge clk);
    idle();
    chk("R5 back-to-back vl", 64'(vl), 64'd5);
    chk("R5 back-to-back maxvl kept", 64'(maxvl), 64'd12);
    chk("R7 back-to-back second idx", 64'(wb_idx), 64'd11);
    chk("R7 back-to-back second valid", 64'(wb_valid), 64'd1);
    // R4: new limit above current vl keeps vl
    drive(7'h1F, 12'hFFF, 4'd13, 5'd12, 32'd0);
    @(negedge clk);
    idle();
    chk("R4 keep vl", 64'(vl), 64'd5);
    chk("R4 new limit", 64'(maxvl), 64'd14);

    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 re-reset maxvl", 64'(maxvl), 64'd1);
    chk("R8 re-reset vl", 64'(vl), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule